// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block keeps wall time as a 32-bit count of seconds for a peripheral on a simple register bus. A reference pulse input stands for a slow crystal. Each pulse is one clock-enable strobe. A prescaler counts these pulses and produces one tick per second. Its divide ratio depends on a source-select bit, which chooses between a 32.768 kHz reference and a 38.4 kHz reference. Each tick advances the seconds counter and raises a sticky seconds flag. A 32-bit alarm value is compared with the counter, and a match raises a sticky alarm flag.

Software uses three registers. The control/status word holds the interrupt-level field, the two flags, the interrupt enables, the freeze permission and the run enable. Flags are cleared by writing a one to them. An external freeze request stops the clock while freeze is permitted. The run enable and the source select are not touched by reset, so the clock can survive a soft reset. A single interrupt output combines each flag with its enable.

Top module: `rtc_alarm_top`

## Requirements
- R1: Each one-second tick adds 1 to the seconds counter, which wraps modulo 2^32. Without a tick or a counter write, the counter never changes.
- R2: Control bit 4 chooses the reference. When it is 0, a tick occurs on every DIV_SLOW-th counted reference pulse (default 32768). When it is 1, a tick occurs on every DIV_FAST-th counted pulse (default 38400).
- R3: Every tick sets the seconds flag, which is control bit 7.
- R4: Writing 1 to control bit 7 or to control bit 6 clears the seconds flag or the alarm flag. Writing 0 to either bit leaves that flag as it was. One write can clear both flags. If a set and a clear fall in the same cycle, the set wins.
- R5: The alarm flag (control bit 6) is set by a tick that brings the counter to the alarm value.
- R6: The irq output equals (seconds flag AND bit 3) OR (alarm flag AND bit 2). Bit 3 is the seconds interrupt enable and bit 2 is the alarm interrupt enable.
- R7: While control bit 1 is 1 and the freezeReq input is high, reference pulses are ignored and both the prescaler and the counter hold. If freezeReq is high while bit 1 is 0, it has no effect.
- R8: While control bit 0 (run enable) is 0, the prescaler and the counter hold.
- R9: Reset leaves control bits 0 and 4 unchanged. Reset clears every other control field, the counter, the alarm value and the prescaler.
- R10: Control bits 15:8 form a read/write interrupt-level field. Bit 5 always reads 0. Reads of any register have no side effects.
- R11: While the counter is frozen at the alarm value, the alarm flag does not set again after it has been cleared.
- R12: A write to the counter clears the prescaler. The next tick therefore comes one full divide period after the write.
- R13: busAddr selects a register: 0 is the control word (in rdata bits 15:0, upper bits 0), 1 is the counter, 2 is the alarm, and 3 reads 0. Writes to the counter and to the alarm load all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One pulse per reference oscillator period |
| freezeReq | input | 1 | External freeze request |
| busWr | input | 1 | Write strobe for the addressed register |
| busAddr | input | 2 | Register select |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
In the bench the divide ratios are cut to 16 and 20, which allows many seconds per run. Directed runs of exactly one pulse short of a period and of a full period tell the two divide ratios apart. These runs also separate a prescaler that restarts on a counter write from one that keeps its old phase. Freeze requests are combined with freeze permission on and off, and the run enable is cleared, which tells real holds apart from ignored inputs. Random rounds then mix the source select, the freeze permission, the pulse spacing and the per-pulse freeze requests. In each round the counter and the seconds flag are compared with a floor division of the pulses that counted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int CTRL_W = 16;
  localparam int LVL_W  = 8;

  // control word bit positions
  localparam int B_EN  = 0;
  localparam int B_FRZ = 1;
  localparam int B_ALE = 2;
  localparam int B_SIE = 3;
  localparam int B_SRC = 4;
  localparam int B_ALR = 6;
  localparam int B_SEC = 7;
  localparam int B_LVL = 8;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_ALARM = 2'd2,
    REG_SPARE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic loadCount;
    logic loadAlarm;
    logic clrSec;
    logic clrAlr;
  } dpStrobe_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_SLOW = 32768,
  parameter int DIV_FAST = 38400,
  parameter int PRESC_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refTick,
  input  logic                freezeReq,
  input  logic                busWr,
  input  logic [1:0]          busAddr,
  input  logic [CTRL_W-1:0]   ctrlWdata,
  output dpStrobe_t           strb,
  output logic                runEn,
  output logic                srcSel,
  output logic                frzEn,
  output logic                secIe,
  output logic                alrIe,
  output logic [LVL_W-1:0]    irqLevel,
  output logic [PRESC_W-1:0]  presc
);

  localparam logic [PRESC_W-1:0] LAST_SLOW = PRESC_W'(DIV_SLOW - 1);
  localparam logic [PRESC_W-1:0] LAST_FAST = PRESC_W'(DIV_FAST - 1);

  logic wrCtrl, wrCount, wrAlarm;
  logic running, atLast;
  logic [PRESC_W-1:0] lastVal;
  logic unusedRsvd;

  assign unusedRsvd = ctrlWdata[5];

  assign wrCtrl  = busWr && (busAddr == REG_CTRL);
  assign wrCount = busWr && (busAddr == REG_COUNT);
  assign wrAlarm = busWr && (busAddr == REG_ALARM);

  assign running = runEn && !(frzEn && freezeReq);
  assign lastVal = srcSel ? LAST_FAST : LAST_SLOW;
  assign atLast  = (presc >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (wrCount) begin
      presc <= '0;
    end else if (running && refTick) begin
      presc <= atLast ? '0 : presc + 1'b1;
    end
  end

  // fields that reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqLevel <= '0;
      secIe    <= 1'b0;
      alrIe    <= 1'b0;
      frzEn    <= 1'b0;
    end else if (wrCtrl) begin
      irqLevel <= ctrlWdata[B_LVL +: LVL_W];
      secIe    <= ctrlWdata[B_SIE];
      alrIe    <= ctrlWdata[B_ALE];
      frzEn    <= ctrlWdata[B_FRZ];
    end
  end

  // fields kept through reset
  always_ff @(posedge clk) begin
    if (wrCtrl) begin
      runEn  <= ctrlWdata[B_EN];
      srcSel <= ctrlWdata[B_SRC];
    end
  end

  always_comb begin
    strb.tick      = running && refTick && atLast && !wrCount;
    strb.loadCount = wrCount;
    strb.loadAlarm = wrAlarm;
    strb.clrSec    = wrCtrl && ctrlWdata[B_SEC];
    strb.clrAlr    = wrCtrl && ctrlWdata[B_ALR];
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm,
  output logic             secFlag,
  output logic             alrFlag
);

  logic [CNT_W-1:0] nextCount;
  logic             hitAlarm;

  assign nextCount = count + 1'b1;
  assign hitAlarm  = (nextCount == alarm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.loadCount) begin
      count <= loadVal;
    end else if (strb.tick) begin
      count <= nextCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarm <= '0;
    end else if (strb.loadAlarm) begin
      alarm <= loadVal;
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secFlag <= 1'b0;
      alrFlag <= 1'b0;
    end else begin
      if (strb.tick)        secFlag <= 1'b1;
      else if (strb.clrSec) secFlag <= 1'b0;
      if (strb.tick && hitAlarm) alrFlag <= 1'b1;
      else if (strb.clrAlr)      alrFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int DIV_SLOW = 32768,
  parameter int DIV_FAST = 38400,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             freezeReq,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic             irq
);

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PRESC_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  dpStrobe_t          strb;
  logic               runEn, srcSel, frzEn, secIe, alrIe;
  logic [LVL_W-1:0]   irqLevel;
  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   count, alarm;
  logic               secFlag, alrFlag;
  logic [CTRL_W-1:0]  ctrlWord;

  rtc_ctrl #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_FAST(DIV_FAST),
    .PRESC_W (PRESC_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .freezeReq(freezeReq),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .ctrlWdata(busWdata[CTRL_W-1:0]),
    .strb     (strb),
    .runEn    (runEn),
    .srcSel   (srcSel),
    .frzEn    (frzEn),
    .secIe    (secIe),
    .alrIe    (alrIe),
    .irqLevel (irqLevel),
    .presc    (presc)
  );

  rtc_datapath #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .loadVal(busWdata),
    .count  (count),
    .alarm  (alarm),
    .secFlag(secFlag),
    .alrFlag(alrFlag)
  );

  assign ctrlWord = {irqLevel, secFlag, alrFlag, 1'b0, srcSel, secIe, alrIe, frzEn, runEn};

  always_comb begin
    case (busAddr)
      REG_CTRL:  busRdata = CNT_W'(ctrlWord);
      REG_COUNT: busRdata = count;
      REG_ALARM: busRdata = alarm;
      default:   busRdata = '0;
    endcase
  end

  assign irq = (secFlag && secIe) || (alrFlag && alrIe);

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic [1:0]         busAddr,
  input logic               clrSecBit,
  input logic               freezeReq,
  input logic               irq,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   alarm,
  input logic               secFlag,
  input logic               alrFlag,
  input logic               runEn,
  input logic               frzEn,
  input logic               secIe,
  input logic               alrIe,
  input logic               tick,
  input logic [PRESC_W-1:0] presc
);

  logic cntWrite;
  assign cntWrite = busWr && (busAddr == 2'd1);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R3
  sec_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> secFlag);

  // R4
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secFlag && !(busWr && busAddr == 2'd0 && clrSecBit)) |=> secFlag);

  // R5
  alarm_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (count + 1'b1 == alarm)) |=> alrFlag);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secIe && !alrIe) |-> !irq);

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && frzEn && freezeReq && !cntWrite) |=> ($stable(count) && $stable(presc)));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWrite) |=> $stable(count));

  // R12
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (presc == '0));

endmodule

bind rtc_alarm_top rtc_alarm_chk #(
  .CNT_W  (CNT_W),
  .PRESC_W(PRESC_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .clrSecBit(busWdata[7]),
  .freezeReq(freezeReq),
  .irq      (irq),
  .count    (count),
  .alarm    (alarm),
  .secFlag  (secFlag),
  .alrFlag  (alrFlag),
  .runEn    (runEn),
  .frzEn    (frzEn),
  .secIe    (secIe),
  .alrIe    (alrIe),
  .tick     (strb.tick),
  .presc    (presc)
);

// File: tb/rtc_alarm_top_tb.sv
`timescale 1ns/1ps
module rtc_alarm_top_tb_top;

  localparam int DS = 16;
  localparam int DF = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        freezeReq = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_top #(.DIV_SLOW(DS), .DIV_FAST(DF), .CNT_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .freezeReq(freezeReq),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulse(input bit fz);
    @(negedge clk);
    refTick = 1'b1; freezeReq = fz;
    @(negedge clk);
    refTick = 1'b0; freezeReq = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic pulses(input int n, input bit fz);
    for (int i = 0; i < n; i++) pulse(fz);
  endtask

  function automatic logic [31:0] expCount(input logic [31:0] start, input int counted, input int div);
    return start + 32'(counted / div);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    rd(2'd0, v); check("R9 ctrl after reset", v & 32'h0000FFEE, 32'h0);
    rd(2'd1, v); check("R9 counter after reset", v, 32'h0);
    rd(2'd2, v); check("R9 alarm after reset", v, 32'h0);
    check("R6 irq after reset", {31'b0, irq}, 32'h0);

    // R1 R2 R3 slow divide
    wr(2'd0, 32'h0001);
    pulses(DS - 1, 1'b0);
    rd(2'd1, v); check("R2 no tick one pulse short", v, 32'd0);
    pulse(1'b0);
    rd(2'd1, v); check("R1 counter advanced", v, 32'd1);
    rd(2'd0, v); check("R3 sec flag set", v & 32'h80, 32'h80);
    check("R6 irq masked", {31'b0, irq}, 32'h0);

    // R4 R6 write-zero leaves flag, write-one clears
    wr(2'd0, 32'h0009);
    check("R6 irq from sec", {31'b0, irq}, 32'h1);
    rd(2'd0, v); check("R4 write 0 keeps sec", v, 32'h0089);
    wr(2'd0, 32'h0089);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);
    rd(2'd0, v); check("R4 sec cleared", v, 32'h0009);

    // R10 level field, reserved bit, read twice
    wr(2'd0, 32'hA529);
    rd(2'd0, v); check("R10 level and reserved", v, 32'h0000A509);
    rd(2'd0, v); check("R10 reread unchanged", v, 32'h0000A509);

    // R2 fast divide, R13 counter load
    wr(2'd0, 32'h0011);
    wr(2'd1, 32'd100);
    pulses(DF - 1, 1'b0);
    rd(2'd1, v); check("R2 fast one short", v, 32'd100);
    pulse(1'b0);
    rd(2'd1, v); check("R2 fast tick", v, 32'd101);

    // R12 counter write restarts prescaler
    wr(2'd0, 32'h0081);
    pulses(10, 1'b0);
    wr(2'd1, 32'd5);
    pulses(DS - 1, 1'b0);
    rd(2'd1, v); check("R12 no early tick", v, 32'd5);
    pulse(1'b0);
    rd(2'd1, v); check("R12 full period", v, 32'd6);

    // R5 alarm, R4 double clear
    wr(2'd2, 32'd8);
    wr(2'd0, 32'h00C5);
    wr(2'd1, 32'd6);
    pulses(DS, 1'b0);
    rd(2'd0, v); check("R5 no alarm at 7", v & 32'h40, 32'h0);
    pulses(DS, 1'b0);
    rd(2'd0, v); check("R5 alarm at 8", v & 32'h40, 32'h40);
    check("R6 irq from alarm", {31'b0, irq}, 32'h1);
    rd(2'd2, v); check("R13 alarm readback", v, 32'd8);
    wr(2'd0, 32'h00C5);
    rd(2'd0, v); check("R4 both flags cleared", v, 32'h0005);

    // R7 R11 freeze at alarm value
    wr(2'd0, 32'h0007);
    pulses(40, 1'b1);
    rd(2'd1, v); check("R7 frozen count", v, 32'd8);
    rd(2'd0, v); check("R11 no alarm while frozen", v & 32'h40, 32'h0);
    pulses(DS, 1'b0);
    rd(2'd1, v); check("R7 counts without request", v, 32'd9);
    wr(2'd0, 32'h00C5);
    pulses(DS, 1'b1);
    rd(2'd1, v); check("R7 request ignored without permit", v, 32'd10);

    // R8 run enable off
    wr(2'd0, 32'h00C0);
    pulses(40, 1'b0);
    rd(2'd1, v); check("R8 halted", v, 32'd10);

    // R13 spare address
    rd(2'd3, v); check("R13 spare reads zero", v, 32'h0);

    // R9 retention through reset
    wr(2'd0, 32'h0019);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    rd(2'd0, v); check("R9 en and src kept", v, 32'h0011);
    rd(2'd1, v); check("R9 counter cleared", v, 32'h0);

    // random rounds: R1 R2 R3 R7
    for (int r = 0; r < 30; r++) begin
      bit src = 1'($urandom % 2);
      bit fzEn = 1'($urandom % 2);
      logic [31:0] start = $urandom;
      int n = $urandom % 60;
      int counted = 0;
      int div = src ? DF : DS;
      wr(2'd0, 32'h00C1 | (32'(src) << 4) | (32'(fzEn) << 1));
      wr(2'd1, start);
      for (int p = 0; p < n; p++) begin
        bit fz = ($urandom % 4) == 0;
        pulse(fz);
        if (!(fzEn && fz)) counted++;
      end
      rd(2'd1, v); check("R1 R2 R7 random count", v, expCount(start, counted, div));
      rd(2'd0, v); check("R3 random sec flag", v & 32'h80, (counted >= div) ? 32'h80 : 32'h0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule